// File: doc/BRIEF.md
# DMA Descriptor Command Sequencer

This block is the control engine of one DMA channel. Software builds a chain of 16-byte descriptors in memory, then pulses `start` with the address of the first one. The sequencer reads each descriptor over a single-outstanding memory request port and decodes its command. It runs a data transfer through a request/done handshake to the device data path, or it moves one word between memory and the descriptor, or it does nothing, or it halts the channel. A finished transfer has its status and residual byte count written back into the descriptor's last word.

Every descriptor also carries two 2-bit selectors. One decides whether the channel parks after the command. The other decides whether the chain continues at the next descriptor or jumps to an address held in the descriptor. Both are judged against one condition. That condition is formed by masking the 8-bit channel status and comparing it with a value, and the mask and value come from the `sel_reg` input. A per-descriptor flag requests a one-cycle `irq` pulse when the sequencer leaves that descriptor.

Top module: `dsq_top`

## Requirements
- R1: During and straight after reset, `active`, `mem_req`, `dev_req` and `irq` are 0 and `cmd_ptr` is 0.
- R2: A `start` pulse loads `cmd_ptr` from `start_addr` and sets `active`. The sequencer then reads descriptor words 0, 1 and 2 at `cmd_ptr`, `cmd_ptr+4` and `cmd_ptr+8`. Memory requests are made only while `active` is 1, and each request holds its address until `mem_ack`.
- R3: Descriptor word 0 holds the request count in bits [15:0] and the command in bits [31:16]. Word 1 is the transfer or word address, word 2 is the branch address or store data, and word 3 is the write-back word. Command bits [31:28] are the opcode: 0 output-more, 1 output-last, 2 input-more, 3 input-last, 4 load-word, 5 store-word, 6 no-op, 7 stop. Opcodes 8 to 15 act as no-op. Bit 24 is the interrupt flag, bits [21:20] the wait selector and bits [19:18] the branch selector.
- R4: When a device is attached (`dev_present`=1), a transfer command raises `dev_req` with `dev_addr` = word 1 and `dev_len` = request count. `dev_out` is 1 for the output opcodes and `dev_last` is 1 for the two last opcodes. These outputs hold until `dev_done`.
- R5: After a transfer, word 3 at `cmd_ptr+12` is written with the residual count in bits [15:0] and the channel status in bits [23:16]. The status byte is `{active, 3'b000, dev_stat}`. No other command writes word 3.
- R6: A transfer with `dev_present`=0 raises no `dev_req`. It still completes and writes back the request count as the residual.
- R7: Load-word reads the word at word 1's address and writes it into word 2 of the descriptor. Store-word writes word 2 to word 1's address.
- R8: Stop clears `active` and leaves `cmd_ptr` unchanged. A `wake` pulse while the channel is stopped restarts fetching at that same `cmd_ptr`.
- R9: The condition is true when (status AND `sel_reg[15:8]`) equals `sel_reg[7:0]`.
- R10: The branch selector codes are 0 never, 1 if the condition is true, 2 if the condition is false, and 3 always. A taken branch sets `cmd_ptr` to word 2. Otherwise `cmd_ptr` advances by 16.
- R11: The wait selector uses the same codes. While the wait holds, the channel issues no requests and keeps `cmd_ptr`. It moves on when `wake` pulses or when the wait condition stops holding.
- R12: A descriptor with the interrupt flag set gives exactly one cycle of `irq` when the sequencer moves past it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; loads the command pointer |
| start_addr | input | 32 | First descriptor address |
| wake | input | 1 | Wake pulse: resumes a stopped or waiting channel |
| dev_stat | input | 4 | Device status bits, low nibble of channel status |
| sel_reg | input | 16 | Condition mask [15:8] and value [7:0] |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory request accepted / read data valid |
| mem_rdata | input | 32 | Memory read data |
| dev_present | input | 1 | A device is attached to the channel |
| dev_req | output | 1 | Transfer request to the device |
| dev_out | output | 1 | Transfer direction, 1 = output |
| dev_last | output | 1 | Transfer ends the data stream |
| dev_addr | output | 32 | Transfer buffer address |
| dev_len | output | 16 | Requested byte count |
| dev_done | input | 1 | Transfer finished |
| dev_resid | input | 16 | Bytes left over at completion |
| active | output | 1 | Channel active status bit |
| cmd_ptr | output | 32 | Current descriptor address |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The checker watches several properties on every cycle. Memory and device requests stay stable until they are acknowledged, and nothing is requested while the channel is inactive or parked in a wait. Each step of the pointer, to the next descriptor or to the branch target, is checked as it happens, as is the fact that stop keeps the pointer. The write-back always lands at the descriptor's fourth word, and every interrupt pulse follows a move to the next descriptor. Only the bench scenarios can show whether the condition logic picks the right branch for a given mask, value and status, and what values land in memory for write-back, load and store. The same holds for the no-device shortcut, and for a wait being released by `wake` or by a change in device status.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

  typedef enum logic [3:0] {
    OP_OUT_MORE = 4'd0,
    OP_OUT_LAST = 4'd1,
    OP_IN_MORE  = 4'd2,
    OP_IN_LAST  = 4'd3,
    OP_LOAD     = 4'd4,
    OP_STORE    = 4'd5,
    OP_NOP      = 4'd6,
    OP_STOP     = 4'd7
  } op_e;

  typedef enum logic [1:0] {
    SEL_NEVER  = 2'd0,
    SEL_IFSET  = 2'd1,
    SEL_IFCLR  = 2'd2,
    SEL_ALWAYS = 2'd3
  } sel_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_DECODE, ST_DEV, ST_MEMRD, ST_MEMWR,
    ST_LDWB, ST_WB, ST_POST, ST_WAIT, ST_NEXT
  } state_e;

  // Selector outcome for a given condition bit
  function automatic logic sel_fires(sel_e sel, logic cond);
    case (sel)
      SEL_NEVER:  return 1'b0;
      SEL_IFSET:  return cond;
      SEL_IFCLR:  return !cond;
      default:    return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/dsq_decode.sv
module dsq_decode
  import dsq_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic [DW-1:0]    word0,
  output op_e              op,
  output logic             irq_en,
  output sel_e             wsel,
  output sel_e             bsel,
  output logic [CNT_W-1:0] count,
  output logic             is_xfer,
  output logic             is_out,
  output logic             is_last
);
  localparam int CMD_W = DW - CNT_W;

  logic [CMD_W-1:0] cmd;
  logic             unused_cmd_bits;

  assign cmd   = word0[DW-1:CNT_W];
  assign count = word0[CNT_W-1:0];

  always_comb begin
    if (cmd[CMD_W-1:CMD_W-4] > 4'd7) op = OP_NOP;
    else                             op = op_e'(cmd[CMD_W-1:CMD_W-4]);
  end

  assign irq_en  = cmd[8];
  assign wsel    = sel_e'(cmd[5:4]);
  assign bsel    = sel_e'(cmd[3:2]);
  assign is_xfer = (op == OP_OUT_MORE) || (op == OP_OUT_LAST) ||
                   (op == OP_IN_MORE)  || (op == OP_IN_LAST);
  assign is_out  = (op == OP_OUT_MORE) || (op == OP_OUT_LAST);
  assign is_last = (op == OP_OUT_LAST) || (op == OP_IN_LAST);

  assign unused_cmd_bits = ^{cmd[CMD_W-5:9], cmd[7:6], cmd[1:0]};
endmodule

// File: rtl/dsq_cond.sv
module dsq_cond
  import dsq_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic [STAT_W-1:0] status,
  input  logic [STAT_W-1:0] mask,
  input  logic [STAT_W-1:0] value,
  input  sel_e              sel,
  output logic              cond,
  output logic              fire
);
  assign cond = ((status & mask) == value);
  assign fire = sel_fires(sel, cond);
endmodule

// File: rtl/dsq_top.sv
module dsq_top
  import dsq_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int CNT_W  = 16,
  parameter int STAT_W = 8,
  parameter int DEV_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [AW-1:0]       start_addr,
  input  logic                wake,
  input  logic [DEV_W-1:0]    dev_stat,
  input  logic [2*STAT_W-1:0] sel_reg,
  output logic                mem_req,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [DW-1:0]       mem_wdata,
  input  logic                mem_ack,
  input  logic [DW-1:0]       mem_rdata,
  input  logic                dev_present,
  output logic                dev_req,
  output logic                dev_out,
  output logic                dev_last,
  output logic [AW-1:0]       dev_addr,
  output logic [CNT_W-1:0]    dev_len,
  input  logic                dev_done,
  input  logic [CNT_W-1:0]    dev_resid,
  output logic                active,
  output logic [AW-1:0]       cmd_ptr,
  output logic                irq
);
  localparam int WORD_BYTES  = DW / 8;
  localparam int DESC_BYTES  = 16;
  localparam int FETCH_WORDS = 3;  // word 3 is write-only
  localparam int IDX_W       = $clog2(FETCH_WORDS);
  localparam int DEP_OFS     = 2 * WORD_BYTES;
  localparam int WB_OFS      = DESC_BYTES - WORD_BYTES;
  localparam int PAD_W       = DW - CNT_W - STAT_W;

  // Byte address of a descriptor word
  function automatic logic [AW-1:0] word_addr(logic [AW-1:0] base, int unsigned ofs);
    return base + AW'(ofs);
  endfunction

  // Pointer step after a descriptor
  function automatic logic [AW-1:0] step_ptr(logic [AW-1:0] base, logic taken,
                                             logic [AW-1:0] target);
    return taken ? target : base + AW'(DESC_BYTES);
  endfunction

  state_e             state_q;
  logic [IDX_W-1:0]   idx_q;
  logic [AW-1:0]      ptr_q;
  logic               active_q;
  logic [CNT_W-1:0]   resid_q;
  logic [DW-1:0]      ld_data_q;
  logic               irq_q;
  logic [DW-1:0]      desc_q [FETCH_WORDS];

  op_e                op;
  logic               irq_en;
  sel_e               wsel;
  sel_e               bsel;
  logic [CNT_W-1:0]   count;
  logic               is_xfer;
  logic               is_out;
  logic               is_last;
  logic [STAT_W-1:0]  status;
  logic [1:0]         fire_v;
  logic [1:0]         cond_v;

  // Named internal events for the checker
  logic               wait_hit;
  logic               br_taken;
  logic [AW-1:0]      br_addr;
  logic               stop_fire;
  logic               next_fire;
  logic               wb_fire;
  logic               in_wait;
  logic               fetch_last;

  assign status = {active_q, {(STAT_W-1-DEV_W){1'b0}}, dev_stat};

  dsq_decode #(.DW(DW), .CNT_W(CNT_W)) u_decode (
    .word0   (desc_q[0]),
    .op      (op),
    .irq_en  (irq_en),
    .wsel    (wsel),
    .bsel    (bsel),
    .count   (count),
    .is_xfer (is_xfer),
    .is_out  (is_out),
    .is_last (is_last)
  );

  // Index 0 judges the wait selector, index 1 the branch selector
  for (genvar g = 0; g < 2; g++) begin : g_cond
    dsq_cond #(.STAT_W(STAT_W)) u_cond (
      .status (status),
      .mask   (sel_reg[2*STAT_W-1:STAT_W]),
      .value  (sel_reg[STAT_W-1:0]),
      .sel    ((g == 0) ? wsel : bsel),
      .cond   (cond_v[g]),
      .fire   (fire_v[g])
    );
  end

  assign wait_hit   = fire_v[0];
  assign br_taken   = fire_v[1];
  assign br_addr    = AW'(desc_q[2]);
  assign stop_fire  = (state_q == ST_DECODE) && (op == OP_STOP);
  assign next_fire  = (state_q == ST_NEXT);
  assign wb_fire    = (state_q == ST_WB) && mem_ack;
  assign in_wait    = (state_q == ST_WAIT);
  assign fetch_last = (state_q == ST_FETCH) && mem_ack &&
                      (idx_q == IDX_W'(FETCH_WORDS - 1));

  // Memory port steering
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr_q;
    mem_wdata = '0;
    case (state_q)
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = word_addr(ptr_q, 32'(idx_q) * WORD_BYTES);
      end
      ST_MEMRD: begin
        mem_req  = 1'b1;
        mem_addr = AW'(desc_q[1]);
      end
      ST_MEMWR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = AW'(desc_q[1]);
        mem_wdata = desc_q[2];
      end
      ST_LDWB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = word_addr(ptr_q, DEP_OFS);
        mem_wdata = ld_data_q;
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = word_addr(ptr_q, WB_OFS);
        mem_wdata = {{PAD_W{1'b0}}, status, resid_q};
      end
      default: ;
    endcase
  end

  assign dev_req  = (state_q == ST_DEV);
  assign dev_out  = is_out;
  assign dev_last = is_last;
  assign dev_addr = AW'(desc_q[1]);
  assign dev_len  = count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      ptr_q     <= '0;
      active_q  <= 1'b0;
      resid_q   <= '0;
      ld_data_q <= '0;
      irq_q     <= 1'b0;
      for (int i = 0; i < FETCH_WORDS; i++) desc_q[i] <= '0;
    end else begin
      irq_q <= next_fire && irq_en;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            ptr_q    <= start_addr;
            active_q <= 1'b1;
            idx_q    <= '0;
            state_q  <= ST_FETCH;
          end else if (wake) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            state_q  <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            desc_q[idx_q] <= mem_rdata;
            if (fetch_last) state_q <= ST_DECODE;
            else            idx_q   <= idx_q + 1'b1;
          end
        end
        ST_DECODE: begin
          if (is_xfer) begin
            if (dev_present) begin
              state_q <= ST_DEV;
            end else begin
              resid_q <= count;
              state_q <= ST_WB;
            end
          end else begin
            case (op)
              OP_LOAD:  state_q <= ST_MEMRD;
              OP_STORE: state_q <= ST_MEMWR;
              OP_STOP: begin
                active_q <= 1'b0;
                state_q  <= ST_IDLE;
              end
              default:  state_q <= ST_POST;
            endcase
          end
        end
        ST_DEV: begin
          if (dev_done) begin
            resid_q <= dev_resid;
            state_q <= ST_WB;
          end
        end
        ST_MEMRD: begin
          if (mem_ack) begin
            ld_data_q <= mem_rdata;
            state_q   <= ST_LDWB;
          end
        end
        ST_MEMWR, ST_LDWB, ST_WB: begin
          if (mem_ack) state_q <= ST_POST;
        end
        ST_POST: state_q <= wait_hit ? ST_WAIT : ST_NEXT;
        ST_WAIT: begin
          if (wake || !wait_hit) state_q <= ST_NEXT;
        end
        ST_NEXT: begin
          ptr_q   <= step_ptr(ptr_q, br_taken, br_addr);
          idx_q   <= '0;
          state_q <= ST_FETCH;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign active  = active_q;
  assign cmd_ptr = ptr_q;
  assign irq     = irq_q;
endmodule

// File: rtl/dsq_checker.sv
module dsq_checker #(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             active,
  input logic [AW-1:0]    cmd_ptr,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic [AW-1:0]    mem_addr,
  input logic             dev_req,
  input logic             dev_done,
  input logic [CNT_W-1:0] dev_len,
  input logic             irq,
  input logic             stop_fire,
  input logic             next_fire,
  input logic             br_taken,
  input logic [AW-1:0]    br_addr,
  input logic             wb_fire,
  input logic             in_wait
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !active && !mem_req && !dev_req && !irq);

  assert_req_only_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> active);

  assert_mem_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_dev_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req && !dev_done |=> dev_req && $stable(dev_len));

  assert_wb_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> mem_we && (mem_addr == cmd_ptr + AW'(12)));

  assert_stop_keeps_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_fire |=> !active && (cmd_ptr == $past(cmd_ptr)));

  assert_step_seq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    next_fire && !br_taken |=> cmd_ptr == $past(cmd_ptr) + AW'(16));

  assert_step_branch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    next_fire && br_taken |=> cmd_ptr == $past(br_addr));

  assert_wait_parked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> !mem_req && !dev_req && active);

  assert_irq_after_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(next_fire));

  assert_irq_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

bind dsq_top dsq_checker #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .active    (active),
  .cmd_ptr   (cmd_ptr),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .dev_req   (dev_req),
  .dev_done  (dev_done),
  .dev_len   (dev_len),
  .irq       (irq),
  .stop_fire (stop_fire),
  .next_fire (next_fire),
  .br_taken  (br_taken),
  .br_addr   (br_addr),
  .wb_fire   (wb_fire),
  .in_wait   (in_wait)
);

// File: tb/test_dsq_top.sv
module test_dsq_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] start_addr;
  logic        wake;
  logic [3:0]  dev_stat;
  logic [15:0] sel_reg;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic        dev_present;
  logic        dev_req, dev_out, dev_last;
  logic [31:0] dev_addr;
  logic [15:0] dev_len;
  logic        dev_done;
  logic [15:0] dev_resid;
  logic        active;
  logic [31:0] cmd_ptr;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] mem [64];

  always #5 clk = ~clk;

  dsq_top i_dsq_top (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .wake(wake), .dev_stat(dev_stat), .sel_reg(sel_reg),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dev_present(dev_present), .dev_req(dev_req), .dev_out(dev_out),
    .dev_last(dev_last), .dev_addr(dev_addr), .dev_len(dev_len),
    .dev_done(dev_done), .dev_resid(dev_resid), .active(active),
    .cmd_ptr(cmd_ptr), .irq(irq)
  );

  // Memory model: acknowledge one cycle after a request
  initial mem_ack = 1'b0;
  always @(posedge clk) begin
    mem_ack   <= mem_req && !mem_ack;
    mem_rdata <= mem[mem_addr[7:2]];
    if (mem_req && mem_we && !mem_ack) mem[mem_addr[7:2]] <= mem_wdata;
  end

  // Device model: done one cycle later, consuming half the length
  initial dev_done = 1'b0;
  always @(posedge clk) begin
    dev_done  <= dev_req && !dev_done;
    dev_resid <= dev_len >> 1;
  end

  // Monitors
  int          dev_starts = 0;
  int          irq_count  = 0;
  logic        dev_req_d  = 1'b0;
  logic        cap_out, cap_last;
  logic [31:0] cap_addr;
  logic [15:0] cap_len;
  always @(negedge clk) begin
    dev_req_d <= dev_req;
    if (irq) irq_count <= irq_count + 1;
    if (dev_req && !dev_req_d) begin
      dev_starts <= dev_starts + 1;
      cap_out  <= dev_out;
      cap_last <= dev_last;
      cap_addr <= dev_addr;
      cap_len  <= dev_len;
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog (all) actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cmdw(logic [3:0] op, logic ien, logic [1:0] ws,
                                       logic [1:0] bs, logic [15:0] cnt);
    return {op, 3'b000, ien, 2'b00, ws, bs, 2'b00, cnt};
  endfunction

  task automatic put(int byte_addr, logic [31:0] v);
    mem[byte_addr >> 2] <= v;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] <= 32'hDEAD_BEEF;
  endtask

  task automatic wait_idle(string req);
    int t = 0;
    @(negedge clk);
    while (active && t < 2000) begin
      @(negedge clk);
      t++;
    end
    if (active) begin
      n_bad++;
      $display("FAIL %s actual=still-active expected=idle", req);
    end
  endtask

  task automatic kick(logic [31:0] a);
    @(negedge clk);
    start_addr = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
  endtask

  // {sel_reg, dev_stat, branch selector, expected final cmd_ptr}
  localparam logic [53:0] VECS [8] = '{
    {16'h0000, 4'h0, 2'd0, 32'h0000_0010},
    {16'h0000, 4'h0, 2'd3, 32'h0000_0040},
    {16'h0F05, 4'h5, 2'd1, 32'h0000_0040},
    {16'h0F05, 4'h4, 2'd1, 32'h0000_0010},
    {16'h0F05, 4'h4, 2'd2, 32'h0000_0040},
    {16'h0F05, 4'h5, 2'd2, 32'h0000_0010},
    {16'h8080, 4'h0, 2'd1, 32'h0000_0040},
    {16'h0001, 4'h0, 2'd1, 32'h0000_0010}
  };

  initial begin
    int irq0;
    int dev0;
    rst_n = 1'b0; start = 1'b0; start_addr = '0; wake = 1'b0;
    dev_stat = '0; sel_reg = '0; dev_present = 1'b1;
    clear_mem();
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 active", {31'b0, active}, 32'h0);
    check("R1 mem_req", {31'b0, mem_req}, 32'h0);
    check("R1 dev_req/irq", {30'b0, dev_req, irq}, 32'h0);
    check("R1 cmd_ptr", cmd_ptr, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9/R10: branch decisions walked from the table
    foreach (VECS[k]) begin
      clear_mem();
      put(32'h00, cmdw(4'd6, 1'b0, 2'd0, VECS[k][33:32], 16'h0));
      put(32'h08, 32'h0000_0040);
      put(32'h10, cmdw(4'd7, 1'b0, 2'd0, 2'd0, 16'h0));
      put(32'h40, cmdw(4'd7, 1'b0, 2'd0, 2'd0, 16'h0));
      sel_reg  = VECS[k][53:38];
      dev_stat = VECS[k][37:34];
      kick(32'h0);
      wait_idle("R10");
      check("R10 R9 branch target", cmd_ptr, VECS[k][31:0]);
    end
    check("R5 no write-back for no-op", mem[3], 32'hDEAD_BEEF);

    // R4/R5: output-last with a device attached
    clear_mem();
    sel_reg = '0; dev_stat = 4'h3; dev_present = 1'b1;
    dev0 = dev_starts;
    put(32'h00, cmdw(4'd1, 1'b0, 2'd0, 2'd0, 16'h0020));
    put(32'h04, 32'h0000_1234);
    put(32'h10, cmdw(4'd7, 1'b0, 2'd0, 2'd0, 16'h0));
    kick(32'h0);
    wait_idle("R4");
    check("R4 dev request count", 32'(dev_starts - dev0), 32'd1);
    check("R4 dev_out/dev_last", {30'b0, cap_out, cap_last}, 32'h3);
    check("R4 dev_addr", cap_addr, 32'h0000_1234);
    check("R4 dev_len", {16'b0, cap_len}, 32'h0000_0020);
    check("R5 write-back word", mem[3], 32'h0083_0010);

    // R4: input-more direction flags
    clear_mem();
    dev_stat = 4'h0;
    put(32'h00, cmdw(4'd2, 1'b0, 2'd0, 2'd0, 16'h0008));
    put(32'h10, cmdw(4'd7, 1'b0, 2'd0, 2'd0, 16'h0));
    kick(32'h0);
    wait_idle("R4");
    check("R4 input-more flags", {30'b0, cap_out, cap_last}, 32'h0);
    check("R5 input write-back", mem[3], 32'h0080_0004);

    // R6: no device attached
    clear_mem();
    dev_present = 1'b0;
    dev0 = dev_starts;
    put(32'h00, cmdw(4'd3, 1'b0, 2'd0, 2'd0, 16'h0055));
    put(32'h10, cmdw(4'd7, 1'b0, 2'd0, 2'd0, 16'h0));
    kick(32'h0);
    wait_idle("R6");
    check("R6 no dev_req", 32'(dev_starts - dev0), 32'd0);
    check("R6 residual equals request count", mem[3], 32'h0080_0055);
    dev_present = 1'b1;

    // R7: load then store, stop at 0x20
    clear_mem();
    put(32'h00, cmdw(4'd4, 1'b0, 2'd0, 2'd0, 16'h0));
    put(32'h04, 32'h0000_0080);
    put(32'h80, 32'hCAFE_F00D);
    put(32'h10, cmdw(4'd5, 1'b0, 2'd0, 2'd0, 16'h0));
    put(32'h14, 32'h0000_0084);
    put(32'h18, 32'h1357_2468);
    put(32'h20, cmdw(4'd7, 1'b0, 2'd0, 2'd0, 16'h0));
    kick(32'h0);
    wait_idle("R7");
    check("R7 load into word 2", mem[2], 32'hCAFE_F00D);
    check("R7 store from word 2", mem[33], 32'h1357_2468);
    check("R8 stop keeps pointer", cmd_ptr, 32'h0000_0020);

    // R8/R12: wake resumes at the stop address; irq flag on a no-op
    irq0 = irq_count;
    put(32'h20, cmdw(4'd6, 1'b1, 2'd0, 2'd0, 16'h0));
    put(32'h30, cmdw(4'd7, 1'b0, 2'd0, 2'd0, 16'h0));
    pulse_wake();
    wait_idle("R8");
    check("R8 resumed from stop address", cmd_ptr, 32'h0000_0030);
    check("R12 one irq pulse", 32'(irq_count - irq0), 32'd1);

    // R11: wait always, released by wake
    clear_mem();
    put(32'h00, cmdw(4'd6, 1'b0, 2'd3, 2'd0, 16'h0));
    put(32'h10, cmdw(4'd7, 1'b0, 2'd0, 2'd0, 16'h0));
    kick(32'h0);
    repeat (30) @(negedge clk);
    check("R11 parked active", {31'b0, active}, 32'h1);
    check("R11 parked pointer", cmd_ptr, 32'h0);
    check("R11 parked no request", {31'b0, mem_req}, 32'h0);
    pulse_wake();
    wait_idle("R11");
    check("R11 wake releases wait", cmd_ptr, 32'h0000_0010);

    // R11/R9: wait if condition true, released by status change
    clear_mem();
    sel_reg = 16'h0F09; dev_stat = 4'h9;
    put(32'h00, cmdw(4'd6, 1'b0, 2'd1, 2'd0, 16'h0));
    put(32'h10, cmdw(4'd7, 1'b0, 2'd0, 2'd0, 16'h0));
    kick(32'h0);
    repeat (30) @(negedge clk);
    check("R11 conditional wait holds", {cmd_ptr[30:0], active}, 32'h1);
    dev_stat = 4'h0;
    wait_idle("R11");
    check("R11 condition change releases", cmd_ptr, 32'h0000_0010);

    // R3: undefined opcode behaves as no-op (no device request, no write-back)
    clear_mem();
    sel_reg = '0;
    dev0 = dev_starts;
    put(32'h00, cmdw(4'd12, 1'b0, 2'd0, 2'd0, 16'h0010));
    put(32'h10, cmdw(4'd7, 1'b0, 2'd0, 2'd0, 16'h0));
    kick(32'h0);
    wait_idle("R3");
    check("R3 undefined opcode as no-op", {mem[3][31:1], 1'b0} ^ {31'b0, 1'b0},
          32'hDEAD_BEEE);
    check("R3 undefined opcode no dev_req", 32'(dev_starts - dev0), 32'd0);
    check("R2 chain ends at second descriptor", cmd_ptr, 32'h0000_0010);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule